// File: doc/BRIEF.md
# Function-Decoded 32-bit ALU

This block is a purely combinational arithmetic and logic unit. It takes two operands, a carry-in and a 5-bit function code, and produces a result word and five flags: carry-out, overflow, operand equality, match against the signature register, and zero result. Each of the 32 function codes is decoded into a small set of internal controls. These controls steer one shared adder, a logic unit and a constant generator. Every code outside the defined set gives a fixed, recognisable output.

The unit sits beside a separate signature register. It reads that register's current value on `sig_in` and can return it, combine it with `y`, or compare `y` against it. It drives the result word on `meas_out` as the data that register samples. For the register's control codes (stop, seed, step, restart), the unit returns small fixed constants and fixed flag values. The register's own sequencing is handled outside this block.

Top module: `alu_fdec`

## Requirements
- R1: Code 00000 gives `y`; 00011 gives the two's complement of `y`, with carry-out equal to the carry of 0 + ~y + 1 (1 only when y is 0); 10001 gives ~y; 10010 gives 0.
- R2: Code 01010 gives x & y; 01100 gives x | y; 11000 gives x ^ y; 11011 gives x & ~y; 11101 gives x | ~y.
- R3: Code 11110 gives x + y + carry_in and 01111 gives x + ~y + 1. For both codes, carry-out is the adder's carry from bit 31, and overflow is the signed overflow (operand signs agree and the result sign differs).
- R4: Code 10101 gives x + y + carry_in, and its overflow equals its carry-out. Code 10100 gives x + ~y + 1 with overflow 0. Carry_in affects the two add codes only.
- R5: Code 00101 gives the constant BA040105 hex with carry-out 0.
- R6: Code 00100 gives y ^ sig_in.
- R7: Code 00001 gives sig_in with carry-out 0 and match 0. Code 00010 gives 2 with carry-out 0 and match 1. Code 01000 gives 5 and code 10000 gives 3, both with carry-out 0.
- R8: Every code not named in R1 to R7 gives a result of 0 with all five flags at 1.
- R9: For every defined code, zero is 1 exactly when the result is 0, and equal is 1 exactly when x equals y.
- R10: For every defined code without an override, match is 1 exactly when y equals sig_in. Carry-out and overflow are 0 for every defined code outside the adder codes (R1 negate, R3, R4) unless R7 says otherwise.
- R11: `meas_out` always carries the result word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | 32 | First operand |
| y | input | 32 | Second operand |
| carry_in | input | 1 | Carry into the add codes |
| func | input | 5 | Function code |
| sig_in | input | 32 | Current signature register value |
| result | output | 32 | Result word |
| c_out | output | 1 | Carry-out flag |
| v_out | output | 1 | Overflow flag |
| eq_out | output | 1 | x equals y flag |
| mch_out | output | 1 | y equals signature flag |
| z_out | output | 1 | Zero result flag |
| meas_out | output | 32 | Data measured by the signature register |

## Verification
All 32 codes are applied under each of eight operand sets and both carry-in values. The operand sets are: all zeros, all ones, equal operands, `y` equal to the signature, sign-boundary pairs, and mixed bit patterns. This sweep separates codes that share the adder (signed versus unsigned, add versus subtract) and shows whether carry-in leaks into the subtract codes. Directed cases then target exact signed overflow at 7FFFFFFF + 1, unsigned wrap at FFFFFFFF + 1, x - x giving zero with carry set, negation of zero, and an undefined code. These distinguish the overflow rule, the carry convention and the forced flag values.

// File: rtl/alu_fdec.sv
module alu_fdec #(
  parameter int W = 32,
  parameter logic [W-1:0] KONST = 32'hBA04_0105
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         carry_in,
  input  logic [4:0]   func,
  input  logic [W-1:0] sig_in,
  output logic [W-1:0] result,
  output logic         c_out,
  output logic         v_out,
  output logic         eq_out,
  output logic         mch_out,
  output logic         z_out,
  output logic [W-1:0] meas_out
);

  typedef enum logic [3:0] {
    S_Y, S_NOTY, S_ZERO, S_AND, S_OR, S_XOR, S_ANDN, S_ORN,
    S_SUM, S_KONST, S_YXS, S_SIG, S_K2, S_K3, S_K5
  } rsel_e;

  typedef enum logic [1:0] {V_ZERO, V_SIGNED, V_CARRY} vsel_e;

  rsel_e rsel;
  vsel_e vsel;
  logic  known, use_adder, a_zero, b_inv, cin_ext;
  logic  m_force, m_val;

  always_comb begin
    known = 1'b1; use_adder = 1'b0; a_zero = 1'b0; b_inv = 1'b0; cin_ext = 1'b0;
    m_force = 1'b0; m_val = 1'b0; vsel = V_ZERO; rsel = S_ZERO;
    case (func)
      5'b00000: rsel = S_Y;
      5'b00001: begin rsel = S_SIG; m_force = 1'b1; m_val = 1'b0; end
      5'b00010: begin rsel = S_K2;  m_force = 1'b1; m_val = 1'b1; end
      5'b00011: begin rsel = S_SUM; use_adder = 1'b1; a_zero = 1'b1; b_inv = 1'b1; end
      5'b00100: rsel = S_YXS;
      5'b00101: rsel = S_KONST;
      5'b01000: rsel = S_K5;
      5'b01010: rsel = S_AND;
      5'b01100: rsel = S_OR;
      5'b01111: begin rsel = S_SUM; use_adder = 1'b1; b_inv = 1'b1; vsel = V_SIGNED; end
      5'b10000: rsel = S_K3;
      5'b10001: rsel = S_NOTY;
      5'b10010: rsel = S_ZERO;
      5'b10100: begin rsel = S_SUM; use_adder = 1'b1; b_inv = 1'b1; end
      5'b10101: begin rsel = S_SUM; use_adder = 1'b1; cin_ext = 1'b1; vsel = V_CARRY; end
      5'b11000: rsel = S_XOR;
      5'b11011: rsel = S_ANDN;
      5'b11101: rsel = S_ORN;
      5'b11110: begin rsel = S_SUM; use_adder = 1'b1; cin_ext = 1'b1; vsel = V_SIGNED; end
      default:  known = 1'b0;
    endcase
  end

  logic [W-1:0] opa, opb, sum, r_core;
  logic         cin, c_low, c_top, v_core;
  logic [W-1:0] lo;
  logic [1:0]   hi;

  assign opa = a_zero ? '0 : x;
  assign opb = b_inv ? ~y : y;
  assign cin = cin_ext ? carry_in : 1'b1;

  assign lo    = {1'b0, opa[W-2:0]} + {1'b0, opb[W-2:0]} + {{(W-1){1'b0}}, cin};
  assign c_low = lo[W-1];
  assign hi    = {1'b0, opa[W-1]} + {1'b0, opb[W-1]} + {1'b0, c_low};
  assign c_top = hi[1];
  assign sum   = {hi[0], lo[W-2:0]};

  always_comb begin
    case (rsel)
      S_Y:     r_core = y;
      S_NOTY:  r_core = ~y;
      S_AND:   r_core = x & y;
      S_OR:    r_core = x | y;
      S_XOR:   r_core = x ^ y;
      S_ANDN:  r_core = x & ~y;
      S_ORN:   r_core = x | ~y;
      S_SUM:   r_core = sum;
      S_KONST: r_core = KONST;
      S_YXS:   r_core = y ^ sig_in;
      S_SIG:   r_core = sig_in;
      S_K2:    r_core = W'(2);
      S_K3:    r_core = W'(3);
      S_K5:    r_core = W'(5);
      default: r_core = '0;
    endcase
  end

  always_comb begin
    case (vsel)
      V_SIGNED: v_core = c_low ^ c_top;
      V_CARRY:  v_core = c_top;
      default:  v_core = 1'b0;
    endcase
  end

  assign result   = known ? r_core : '0;
  assign c_out    = known ? (use_adder & c_top) : 1'b1;
  assign v_out    = known ? v_core : 1'b1;
  assign eq_out   = known ? (x == y) : 1'b1;
  assign mch_out  = !known ? 1'b1 : (m_force ? m_val : (y == sig_in));
  assign z_out    = known ? (r_core == '0) : 1'b1;
  assign meas_out = result;

endmodule

module alu_fdec_chk #(
  parameter int W = 32,
  parameter logic [W-1:0] KONST = 32'hBA04_0105
) (
  input logic [W-1:0] x,
  input logic [W-1:0] y,
  input logic [4:0]   func,
  input logic [W-1:0] result,
  input logic         c_out,
  input logic         v_out,
  input logic         eq_out,
  input logic         z_out
);
  function automatic logic listed(input logic [4:0] f);
    case (f)
      5'b00000, 5'b00001, 5'b00010, 5'b00011, 5'b00100, 5'b00101, 5'b01000,
      5'b01010, 5'b01100, 5'b01111, 5'b10000, 5'b10001, 5'b10010, 5'b10100,
      5'b10101, 5'b11000, 5'b11011, 5'b11101, 5'b11110: listed = 1'b1;
      default: listed = 1'b0;
    endcase
  endfunction

  always_comb begin
    if (!listed(func))
      p_unlisted_r8: assert (result == '0 && c_out && v_out && eq_out && z_out);
    if (func == 5'b00101)
      p_konst_r5: assert (result == KONST && !c_out);
    if (func == 5'b10101)
      p_uadd_ovf_r4: assert (v_out == c_out);
    if (listed(func))
      p_equal_r9: assert (eq_out == (x == y));
    if (listed(func))
      p_zero_r9: assert (z_out == (result == '0));
  end
endmodule

bind alu_fdec alu_fdec_chk #(.W(W), .KONST(KONST)) u_chk (
  .x(x), .y(y), .func(func), .result(result), .c_out(c_out),
  .v_out(v_out), .eq_out(eq_out), .z_out(z_out)
);

// File: tb/test_alu_fdec.sv
module test_alu_fdec;
  logic [31:0] x, y, sig_in, result, meas_out;
  logic        carry_in, c_out, v_out, eq_out, mch_out, z_out;
  logic [4:0]  func;
  logic        clk = 1'b0;
  int          n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  alu_fdec i_alu_fdec (
    .x(x), .y(y), .carry_in(carry_in), .func(func), .sig_in(sig_in),
    .result(result), .c_out(c_out), .v_out(v_out), .eq_out(eq_out),
    .mch_out(mch_out), .z_out(z_out), .meas_out(meas_out)
  );

  typedef struct packed {
    logic [31:0] r;
    logic c, v, e, m, z;
  } exp_t;

  localparam int NV = 8;
  localparam logic [95:0] STIM [NV] = '{
    {32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1234_5678},
    {32'h1357_9BDF, 32'h1357_9BDF, 32'hFFFF_0000},
    {32'hA5A5_5A5A, 32'h0F0F_F0F0, 32'h0F0F_F0F0},
    {32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000},
    {32'h8000_0000, 32'h0000_0001, 32'hDEAD_BEEF},
    {32'h0000_0005, 32'hFFFF_FFFE, 32'h0000_0000},
    {32'hC001_D00D, 32'h8000_0000, 32'h0000_0003}
  };

  function automatic exp_t model(input logic [4:0] f, input logic [31:0] a,
                                 input logic [31:0] b, input logic ci,
                                 input logic [31:0] s);
    exp_t e;
    logic [32:0] t;
    logic bad, mo, mv;
    e = '0; bad = 1'b0; mo = 1'b0; mv = 1'b0;
    case (f)
      5'b00000: e.r = b;
      5'b00011: begin t = {1'b0, ~b} + 33'd1; e.r = t[31:0]; e.c = t[32]; end
      5'b10001: e.r = ~b;
      5'b10010: e.r = 32'd0;
      5'b01010: e.r = a & b;
      5'b01100: e.r = a | b;
      5'b11000: e.r = a ^ b;
      5'b11011: e.r = a & ~b;
      5'b11101: e.r = a | ~b;
      5'b11110, 5'b10101: begin
        t = {1'b0, a} + {1'b0, b} + {32'd0, ci};
        e.r = t[31:0]; e.c = t[32];
        e.v = (f == 5'b10101) ? t[32] : ((a[31] == b[31]) && (t[31] != a[31]));
      end
      5'b01111, 5'b10100: begin
        t = {1'b0, a} + {1'b0, ~b} + 33'd1;
        e.r = t[31:0]; e.c = t[32];
        e.v = (f == 5'b01111) && (a[31] != b[31]) && (t[31] != a[31]);
      end
      5'b00101: e.r = 32'hBA04_0105;
      5'b00100: e.r = b ^ s;
      5'b00001: begin e.r = s; mo = 1'b1; mv = 1'b0; end
      5'b00010: begin e.r = 32'd2; mo = 1'b1; mv = 1'b1; end
      5'b01000: e.r = 32'd5;
      5'b10000: e.r = 32'd3;
      default:  bad = 1'b1;
    endcase
    if (bad) begin
      e.r = '0; e.c = 1'b1; e.v = 1'b1; e.e = 1'b1; e.m = 1'b1; e.z = 1'b1;
    end else begin
      e.e = (a == b);
      e.m = mo ? mv : (b == s);
      e.z = (e.r == 32'd0);
    end
    return e;
  endfunction

  function automatic string tag_of(input logic [4:0] f);
    case (f)
      5'b00000, 5'b00011, 5'b10001, 5'b10010: return "R1";
      5'b01010, 5'b01100, 5'b11000, 5'b11011, 5'b11101: return "R2";
      5'b11110, 5'b01111: return "R3";
      5'b10101, 5'b10100: return "R4";
      5'b00101: return "R5";
      5'b00100: return "R6";
      5'b00001, 5'b00010, 5'b01000, 5'b10000: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s func=%b x=%h y=%h cin=%b sig=%h act=%h exp=%h",
               tag, what, func, x, y, carry_in, sig_in, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] f, input logic [31:0] a, input logic [31:0] b,
                       input logic ci, input logic [31:0] s);
    @(posedge clk);
    func = f; x = a; y = b; carry_in = ci; sig_in = s;
    @(negedge clk);
  endtask

  task automatic full_check;
    exp_t e;
    string t;
    e = model(func, x, y, carry_in, sig_in);
    t = tag_of(func);
    check(t, "result", result, e.r);
    check(t, "cout", {31'd0, c_out}, {31'd0, e.c});
    check(t, "ovf", {31'd0, v_out}, {31'd0, e.v});
    check("R9", "eq", {31'd0, eq_out}, {31'd0, e.e});
    check("R9", "zero", {31'd0, z_out}, {31'd0, e.z});
    check((t == "R7" || t == "R8") ? t : "R10", "mch", {31'd0, mch_out}, {31'd0, e.m});
    check("R11", "meas", meas_out, result);
  endtask

  initial begin
    #1000000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    func = '0; x = '0; y = '0; carry_in = 1'b0; sig_in = '0;
    @(negedge clk);
    check("R1", "idle result", result, 32'd0);
    check("R9", "idle zero", {31'd0, z_out}, 32'd1);

    for (int v = 0; v < NV; v++)
      for (int f = 0; f < 32; f++)
        for (int ci = 0; ci < 2; ci++) begin
          apply(5'(f), STIM[v][95:64], STIM[v][63:32], ci[0], STIM[v][31:0]);
          full_check();
        end

    apply(5'b11110, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 32'd0);
    check("R3", "signed ovf", {31'd0, v_out}, 32'd1);
    check("R3", "signed sum", result, 32'h8000_0000);
    apply(5'b10101, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 32'd0);
    check("R4", "wrap cout", {31'd0, c_out}, 32'd1);
    check("R4", "wrap ovf", {31'd0, v_out}, 32'd1);
    check("R9", "wrap zero", {31'd0, z_out}, 32'd1);
    apply(5'b10100, 32'h0000_1234, 32'h0000_1234, 1'b0, 32'd0);
    check("R4", "x-x result", result, 32'd0);
    check("R4", "x-x cout", {31'd0, c_out}, 32'd1);
    check("R4", "x-x ovf", {31'd0, v_out}, 32'd0);
    apply(5'b01111, 32'd5, 32'd3, 1'b1, 32'd0);
    check("R4", "carry_in ignored on subtract", result, 32'd2);
    apply(5'b00011, 32'd0, 32'd0, 1'b0, 32'd0);
    check("R1", "negate zero cout", {31'd0, c_out}, 32'd1);
    apply(5'b00101, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 32'd0);
    check("R5", "constant", result, 32'hBA04_0105);
    check("R5", "constant cout", {31'd0, c_out}, 32'd0);
    apply(5'b00110, 32'd1, 32'd2, 1'b0, 32'd7);
    check("R8", "unlisted result", result, 32'd0);
    check("R8", "unlisted flags", {27'd0, c_out, v_out, eq_out, mch_out, z_out}, 32'h1F);
    apply(5'b00001, 32'd0, 32'hABCD_0000, 1'b0, 32'hABCD_0000);
    check("R7", "stop mch forced 0", {31'd0, mch_out}, 32'd0);
    check("R7", "stop returns sig", result, 32'hABCD_0000);
    apply(5'b00100, 32'd0, 32'hF0F0_F0F0, 1'b0, 32'hFF00_FF00);
    check("R6", "y xor sig", result, 32'h0FF0_0FF0);
    apply(5'b01010, 32'd0, 32'h55, 1'b0, 32'h55);
    check("R10", "mch on equal sig", {31'd0, mch_out}, 32'd1);
    check("R10", "logic cout zero", {31'd0, c_out}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule